// File: doc/BRIEF.md
# Fused Undocumented-Operation Execution Unit

This unit is the execution stage for the merged operations of an 8-bit accumulator processor. Each merged operation chains two basic steps into one instruction. Examples are a mask followed by a shift, a load into two registers, a store masked by an address byte, or a memory modify followed by an accumulator operation. The sequencer supplies these inputs in a single cycle:

- the accumulator and the two index registers;
- the stack pointer;
- the fetched operand byte (memory or immediate);
- the high byte of the target address;
- the carry and decimal flags.

One clock later the unit returns the new accumulator, index and stack-pointer values and the byte to write back to memory. It also returns the N, Z, C and V flags. Each result carries its own write enable, so the sequencer commits only what the operation produces. The unit does no operand fetch and no bus sequencing.

Both the decimal arithmetic path and the constant used by the magic-mask operation are parameters.

Top module: `ucx_alu`

## Requirements
- R1: Reset clears `o_valid` and every result output to zero. When `i_valid` is high, the results appear one cycle later with `o_valid` high. After a cycle with `i_valid` low, `o_valid` is low and all result outputs keep their previous values.
- R2: `i_op` codes are: 0 and-carry, 1 and-lsr, 2 and-ror, 3 load-ax, 4 load-spmask, 5 store-ax, 6 magic-ax, 7 store-yh, 8 store-xh, 9 store-axh, 10 shl-or, 11 shr-eor, 12 rol-and, 13 ror-add, 14 dec-cmp, 15 inc-sub. Register write enables are `o_wr_a`, `o_wr_x`, `o_wr_sp` and `o_wr_mem`. Flag bits in `o_flags` and `o_flag_we` are N=bit3, Z=bit2, C=bit1, V=bit0. Each operation raises exactly the enables listed in the requirements below. N is bit 7 of the named value and Z is set when that value is zero.
- R3: and-carry writes A = A&M and writes N, Z and C, with C equal to bit 7 of the result.
- R4: and-lsr writes A = (A&M)>>1, with C taken from bit 0 of A&M. It writes N, Z and C.
- R5: and-ror writes A = {C_in,(A&M)[7:1]}. C is bit 6 of the result and V is bit 6 XOR bit 5. It writes N, Z, C and V, and the rule is the same whatever the decimal flag.
- R6: load-ax writes M to both A and X. load-spmask writes M&SP to A, X and SP. Both write only N and Z.
- R7: magic-ax writes (A | MAGIC) & M to A and X, with MAGIC defaulting to 0xEE. It writes only N and Z.
- R8: The store operations write only memory and no flags. store-ax writes A&X. store-yh writes Y&(H+1), store-xh writes X&(H+1) and store-axh writes A&X&(H+1). H+1 wraps modulo 256.
- R9: The modify-then-logic operations all write the modified byte to memory and the logic result to A. shl-or writes M<<1 and A|that. shr-eor writes M>>1 and A^that. rol-and writes {M[6:0],C_in} and A&that. C is the bit shifted out, and N and Z come from the new A.
- R10: ror-add writes S={C_in,M[7:1]} to memory. It then adds A+S+M[0] into A. It writes N, Z, C and V from the binary sum; V is signed overflow.
- R11: dec-cmp writes M-1 to memory and compares it with A, leaving A unchanged. C is set when A >= M-1, and N and Z come from A-(M-1).
- R12: inc-sub writes M+1 to memory and computes A-(M+1)-(1-C_in) into A. N, Z, C (no borrow) and V come from the binary difference.
- R13: With the decimal flag set, ror-add and inc-sub write a nibble-corrected result to A. For the add, a nibble above 9 gets 6 added, and C is the carry out of the adjusted high nibble. For the subtract, a negative nibble gets 6 subtracted, and C stays binary. N, Z and V stay binary in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Operation present this cycle |
| i_op | input | 4 | Operation code (R2) |
| i_a | input | 8 | Accumulator |
| i_x | input | 8 | X index register |
| i_y | input | 8 | Y index register |
| i_sp | input | 8 | Stack pointer |
| i_m | input | 8 | Memory or immediate operand |
| i_hi | input | 8 | High byte of target address |
| i_c | input | 1 | Carry flag in |
| i_d | input | 1 | Decimal flag in |
| o_valid | output | 1 | Result valid |
| o_a | output | 8 | New accumulator |
| o_x | output | 8 | New X |
| o_sp | output | 8 | New stack pointer |
| o_mem | output | 8 | Memory write byte |
| o_wr_a | output | 1 | Write enable for A |
| o_wr_x | output | 1 | Write enable for X |
| o_wr_sp | output | 1 | Write enable for SP |
| o_wr_mem | output | 1 | Memory write enable |
| o_flags | output | 4 | N,Z,C,V values |
| o_flag_we | output | 4 | N,Z,C,V write enables |

## Verification
The checker watches the valid timing on every cycle. It also confirms several per-operation properties on every cycle:

- the carry equals the sign after and-carry;
- the top bit is clear after and-lsr;
- A, X and SP agree after load-spmask;
- store-ax leaves registers and flags alone;
- Z tracks a zero accumulator in binary mode.

The exact arithmetic needs the bench's scenarios to show it. This covers the nibble-corrected decimal sums and differences, the V rule of and-ror, the borrow chain of inc-sub, the H+1 wrap, and the full write-enable pattern per opcode. The bench compares those against its own model over random and directed operands.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
    localparam int BW = 8;

    typedef enum logic [3:0] {
        OP_AND_CARRY   = 4'd0,
        OP_AND_LSR     = 4'd1,
        OP_AND_ROR     = 4'd2,
        OP_LOAD_AX     = 4'd3,
        OP_LOAD_SPMASK = 4'd4,
        OP_STORE_AX    = 4'd5,
        OP_MAGIC_AX    = 4'd6,
        OP_STORE_YH    = 4'd7,
        OP_STORE_XH    = 4'd8,
        OP_STORE_AXH   = 4'd9,
        OP_SHL_OR      = 4'd10,
        OP_SHR_EOR     = 4'd11,
        OP_ROL_AND     = 4'd12,
        OP_ROR_ADD     = 4'd13,
        OP_DEC_CMP     = 4'd14,
        OP_INC_SUB     = 4'd15
    } ucx_op_e;

    typedef struct packed {
        logic a;
        logic x;
        logic sp;
        logic mem;
    } ucx_reg_we_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } ucx_flags_t;

    typedef struct packed {
        logic [BW-1:0] a;
        logic [BW-1:0] x;
        logic [BW-1:0] sp;
        logic [BW-1:0] mem;
        ucx_reg_we_t   we;
        ucx_flags_t    fl;
        ucx_flags_t    fl_we;
    } ucx_result_t;

    function automatic logic sign_of(input logic [BW-1:0] v);
        return v[BW-1];
    endfunction

    function automatic logic zero_of(input logic [BW-1:0] v);
        return (v == '0);
    endfunction
endpackage

// File: rtl/ucx_rmw_unit.sv
module ucx_rmw_unit
    import ucx_pkg::*;
(
    input  ucx_op_e       op,
    input  logic [BW-1:0] m,
    input  logic          c_in,
    output logic [BW-1:0] res,
    output logic          c_out
);
    localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

    always_comb begin
        res   = m;
        c_out = c_in;
        case (op)
            OP_SHL_OR: begin
                res   = {m[BW-2:0], 1'b0};
                c_out = m[BW-1];
            end
            OP_SHR_EOR: begin
                res   = {1'b0, m[BW-1:1]};
                c_out = m[0];
            end
            OP_ROL_AND: begin
                res   = {m[BW-2:0], c_in};
                c_out = m[BW-1];
            end
            OP_ROR_ADD: begin
                res   = {c_in, m[BW-1:1]};
                c_out = m[0];
            end
            OP_DEC_CMP: res = m - ONE;
            OP_INC_SUB: res = m + ONE;
            default: ;
        endcase
    end
endmodule

// File: rtl/ucx_dec_adder.sv
module ucx_dec_adder
    import ucx_pkg::*;
#(
    parameter bit DECIMAL_EN = 1'b1
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    input  logic          dec,
    output logic [BW-1:0] bin_sum,
    output logic [BW-1:0] sum,
    output logic          c_out,
    output logic          v_out
);
    logic [BW-1:0] bx;
    logic [BW:0]   wide;
    logic          bin_c;

    always_comb begin
        bx      = sub ? ~b : b;
        wide    = {1'b0, a} + {1'b0, bx} + {{BW{1'b0}}, cin};
        bin_sum = wide[BW-1:0];
        bin_c   = wide[BW];
        v_out   = ~(a[BW-1] ^ bx[BW-1]) & (a[BW-1] ^ bin_sum[BW-1]);
    end

    generate
        if (DECIMAL_EN) begin : g_bcd
            logic [5:0] lo6, hi6;
            logic       lo_ov;
            always_comb begin
                if (!sub) begin
                    lo6 = {2'b0, a[3:0]} + {2'b0, b[3:0]} + {5'b0, cin};
                    if (lo6 > 6'd9) lo6 = lo6 + 6'd6;
                    lo_ov = (lo6 > 6'd15);
                    hi6 = {2'b0, a[7:4]} + {2'b0, b[7:4]} + {5'b0, lo_ov};
                    if (hi6 > 6'd9) hi6 = hi6 + 6'd6;
                end else begin
                    lo6 = {2'b0, a[3:0]} - {2'b0, b[3:0]} - {5'b0, ~cin};
                    lo_ov = lo6[5];
                    if (lo_ov) lo6 = lo6 - 6'd6;
                    hi6 = {2'b0, a[7:4]} - {2'b0, b[7:4]} - {5'b0, lo_ov};
                    if (hi6[5]) hi6 = hi6 - 6'd6;
                end
                if (dec) begin
                    sum   = {hi6[3:0], lo6[3:0]};
                    c_out = sub ? bin_c : (hi6 > 6'd15);
                end else begin
                    sum   = bin_sum;
                    c_out = bin_c;
                end
            end
        end else begin : g_bin
            always_comb begin
                sum   = bin_sum;
                c_out = bin_c;
            end
        end
    endgenerate
endmodule

// File: rtl/ucx_alu.sv
module ucx_alu
    import ucx_pkg::*;
#(
    parameter bit            DECIMAL_EN = 1'b1,
    parameter logic [BW-1:0] MAGIC      = 8'hEE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_valid,
    input  logic [3:0]    i_op,
    input  logic [BW-1:0] i_a,
    input  logic [BW-1:0] i_x,
    input  logic [BW-1:0] i_y,
    input  logic [BW-1:0] i_sp,
    input  logic [BW-1:0] i_m,
    input  logic [BW-1:0] i_hi,
    input  logic          i_c,
    input  logic          i_d,
    output logic          o_valid,
    output logic [BW-1:0] o_a,
    output logic [BW-1:0] o_x,
    output logic [BW-1:0] o_sp,
    output logic [BW-1:0] o_mem,
    output logic          o_wr_a,
    output logic          o_wr_x,
    output logic          o_wr_sp,
    output logic          o_wr_mem,
    output logic [3:0]    o_flags,
    output logic [3:0]    o_flag_we
);
    localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

    ucx_op_e       op;
    logic [BW-1:0] masked, hi_inc, mod, sum, bin_sum, t;
    logic [BW:0]   diff;
    logic          mod_c, add_c, add_v;
    ucx_result_t   r, q;

    assign op     = ucx_op_e'(i_op);
    assign masked = i_a & i_m;
    assign hi_inc = i_hi + ONE;
    assign diff   = {1'b0, i_a} - {1'b0, mod};

    ucx_rmw_unit u_rmw (
        .op(op), .m(i_m), .c_in(i_c), .res(mod), .c_out(mod_c)
    );

    ucx_dec_adder #(.DECIMAL_EN(DECIMAL_EN)) u_add (
        .a(i_a), .b(mod), .cin(mod_c), .sub(op == OP_INC_SUB), .dec(i_d),
        .bin_sum(bin_sum), .sum(sum), .c_out(add_c), .v_out(add_v)
    );

    always_comb begin
        r      = '0;
        r.a    = i_a;
        r.x    = i_x;
        r.sp   = i_sp;
        r.mem  = mod;
        r.fl.c = i_c;
        t      = '0;
        case (op)
            OP_AND_CARRY:   begin t = masked; r.fl.c = masked[BW-1]; end
            OP_AND_LSR:     begin t = {1'b0, masked[BW-1:1]}; r.fl.c = masked[0]; end
            OP_AND_ROR: begin
                t       = {i_c, masked[BW-1:1]};
                r.fl.c  = t[6];
                r.fl.v  = t[6] ^ t[5];
            end
            OP_LOAD_AX:     t = i_m;
            OP_LOAD_SPMASK: t = i_m & i_sp;
            OP_MAGIC_AX:    t = (i_a | MAGIC) & i_m;
            OP_STORE_AX:    r.mem = i_a & i_x;
            OP_STORE_YH:    r.mem = i_y & hi_inc;
            OP_STORE_XH:    r.mem = i_x & hi_inc;
            OP_STORE_AXH:   r.mem = i_a & i_x & hi_inc;
            OP_SHL_OR:      begin t = i_a | mod; r.fl.c = mod_c; end
            OP_SHR_EOR:     begin t = i_a ^ mod; r.fl.c = mod_c; end
            OP_ROL_AND:     begin t = i_a & mod; r.fl.c = mod_c; end
            OP_ROR_ADD, OP_INC_SUB: begin
                t      = bin_sum;
                r.fl.c = add_c;
                r.fl.v = add_v;
            end
            OP_DEC_CMP:     begin t = diff[BW-1:0]; r.fl.c = ~diff[BW]; end
            default: ;
        endcase
        r.fl.n = sign_of(t);
        r.fl.z = zero_of(t);

        case (op)
            OP_AND_CARRY, OP_AND_LSR: begin r.a = t; r.we = 4'b1000; r.fl_we = 4'b1110; end
            OP_AND_ROR:               begin r.a = t; r.we = 4'b1000; r.fl_we = 4'b1111; end
            OP_LOAD_AX, OP_MAGIC_AX:  begin r.a = t; r.x = t; r.we = 4'b1100; r.fl_we = 4'b1100; end
            OP_LOAD_SPMASK: begin
                r.a = t; r.x = t; r.sp = t; r.we = 4'b1110; r.fl_we = 4'b1100;
            end
            OP_STORE_AX, OP_STORE_YH, OP_STORE_XH, OP_STORE_AXH: r.we = 4'b0001;
            OP_SHL_OR, OP_SHR_EOR, OP_ROL_AND: begin r.a = t; r.we = 4'b1001; r.fl_we = 4'b1110; end
            OP_ROR_ADD, OP_INC_SUB:   begin r.a = sum; r.we = 4'b1001; r.fl_we = 4'b1111; end
            OP_DEC_CMP:               begin r.we = 4'b0001; r.fl_we = 4'b1110; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            q       <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) q <= r;
        end
    end

    assign o_a       = q.a;
    assign o_x       = q.x;
    assign o_sp      = q.sp;
    assign o_mem     = q.mem;
    assign o_wr_a    = q.we.a;
    assign o_wr_x    = q.we.x;
    assign o_wr_sp   = q.we.sp;
    assign o_wr_mem  = q.we.mem;
    assign o_flags   = q.fl;
    assign o_flag_we = q.fl_we;
endmodule

// File: rtl/ucx_alu_chk.sv
module ucx_alu_chk
    import ucx_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          i_valid,
    input logic [3:0]    i_op,
    input logic [BW-1:0] i_a,
    input logic [BW-1:0] i_x,
    input logic [BW-1:0] i_sp,
    input logic [BW-1:0] i_m,
    input logic          i_d,
    input logic          o_valid,
    input logic [BW-1:0] o_a,
    input logic [BW-1:0] o_x,
    input logic [BW-1:0] o_sp,
    input logic [BW-1:0] o_mem,
    input logic          o_wr_a,
    input logic          o_wr_x,
    input logic [3:0]    o_flags,
    input logic [3:0]    o_flag_we
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);

    a_r1_idle_drops: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);

    a_r3_carry_is_sign: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_op == OP_AND_CARRY) |=> (o_flags[1] == o_flags[3]) && (o_flags[3] == o_a[7]));

    a_r4_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_op == OP_AND_LSR) |=> !o_a[7] && !o_flags[3]);

    a_r6_triple_load: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_op == OP_LOAD_SPMASK) |=>
            (o_a == o_x) && (o_x == o_sp) && (o_a == ($past(i_m) & $past(i_sp))));

    a_r8_store_quiet: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_op == OP_STORE_AX) |=>
            (o_flag_we == 4'b0) && !o_wr_a && !o_wr_x && (o_mem == ($past(i_a) & $past(i_x))));

    a_r2_zero_tracks_a: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_wr_a && o_flag_we[2] && !$past(i_d)) |-> (o_flags[2] == (o_a == '0)));
endmodule

bind ucx_alu ucx_alu_chk chk_i (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_op(i_op), .i_a(i_a), .i_x(i_x),
    .i_sp(i_sp), .i_m(i_m), .i_d(i_d), .o_valid(o_valid), .o_a(o_a), .o_x(o_x),
    .o_sp(o_sp), .o_mem(o_mem), .o_wr_a(o_wr_a), .o_wr_x(o_wr_x),
    .o_flags(o_flags), .o_flag_we(o_flag_we)
);

// File: tb/ucx_alu_tb.sv
`timescale 1ns/1ps
module ucx_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       i_valid;
    logic [3:0] i_op;
    logic [7:0] i_a, i_x, i_y, i_sp, i_m, i_hi;
    logic       i_c, i_d;
    logic       o_valid;
    logic [7:0] o_a, o_x, o_sp, o_mem;
    logic       o_wr_a, o_wr_x, o_wr_sp, o_wr_mem;
    logic [3:0] o_flags, o_flag_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ucx_alu dut_i (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_op(i_op), .i_a(i_a), .i_x(i_x),
        .i_y(i_y), .i_sp(i_sp), .i_m(i_m), .i_hi(i_hi), .i_c(i_c), .i_d(i_d),
        .o_valid(o_valid), .o_a(o_a), .o_x(o_x), .o_sp(o_sp), .o_mem(o_mem),
        .o_wr_a(o_wr_a), .o_wr_x(o_wr_x), .o_wr_sp(o_wr_sp), .o_wr_mem(o_wr_mem),
        .o_flags(o_flags), .o_flag_we(o_flag_we)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op, input bit d);
        case (op)
            0: return "R3";  1: return "R4";  2: return "R5";
            3, 4: return "R6";  6: return "R7";
            5, 7, 8, 9: return "R8";
            10, 11, 12: return "R9";
            13: return d ? "R13" : "R10";
            14: return "R11";
            default: return d ? "R13" : "R12";
        endcase
    endfunction

    task automatic model(input int op, input int a, x, y, sp, m, hi, c, d,
                         output int ea, ex, esp, emem, ewr, efl, efwe);
        int t, s, bin, bx, lo, hh, neg, ci, res, cf, vf;
        ea = a; ex = x; esp = sp; emem = m; ewr = 0; efwe = 0; cf = c; vf = 0; res = 0;
        t = a & m;
        case (op)
            0: begin res = t; cf = (t >> 7) & 1; ea = res; ewr = 8; efwe = 14; end
            1: begin res = t >> 1; cf = t & 1; ea = res; ewr = 8; efwe = 14; end
            2: begin res = (c << 7) | (t >> 1); cf = (res >> 6) & 1;
                     vf = ((res >> 6) ^ (res >> 5)) & 1; ea = res; ewr = 8; efwe = 15; end
            3: begin res = m; ea = res; ex = res; ewr = 12; efwe = 12; end
            4: begin res = m & sp; ea = res; ex = res; esp = res; ewr = 14; efwe = 12; end
            5: begin emem = a & x; ewr = 1; end
            6: begin res = (a | 8'hEE) & m; ea = res; ex = res; ewr = 12; efwe = 12; end
            7: begin emem = y & ((hi + 1) & 255); ewr = 1; end
            8: begin emem = x & ((hi + 1) & 255); ewr = 1; end
            9: begin emem = a & x & ((hi + 1) & 255); ewr = 1; end
            10, 11, 12: begin
                if (op == 10) begin s = (m << 1) & 255; cf = (m >> 7) & 1; res = a | s; end
                else if (op == 11) begin s = m >> 1; cf = m & 1; res = a ^ s; end
                else begin s = ((m << 1) & 255) | c; cf = (m >> 7) & 1; res = a & s; end
                emem = s; ea = res; ewr = 9; efwe = 14;
            end
            13: begin
                s = (c << 7) | (m >> 1); ci = m & 1; emem = s;
                bin = a + s + ci; res = bin & 255; cf = (bin >> 8) & 1;
                vf = ((~(a ^ s)) & (a ^ res) & 128) != 0;
                ea = res;
                if (d != 0) begin
                    lo = (a & 15) + (s & 15) + ci; if (lo > 9) lo += 6;
                    hh = (a >> 4) + (s >> 4) + (lo > 15 ? 1 : 0); if (hh > 9) hh += 6;
                    ea = ((hh & 15) << 4) | (lo & 15); cf = hh > 15 ? 1 : 0;
                end
                ewr = 9; efwe = 15;
            end
            14: begin
                s = (m - 1) & 255; emem = s;
                res = (a - s) & 255; cf = (a >= s) ? 1 : 0; ewr = 1; efwe = 14;
            end
            default: begin
                s = (m + 1) & 255; emem = s; bx = (~s) & 255;
                bin = a + bx + c; res = bin & 255; cf = (bin >> 8) & 1;
                vf = ((~(a ^ bx)) & (a ^ res) & 128) != 0;
                ea = res;
                if (d != 0) begin
                    lo = (a & 15) - (s & 15) - (1 - c); neg = lo < 0 ? 1 : 0;
                    if (neg != 0) lo -= 6;
                    hh = (a >> 4) - (s >> 4) - neg; if (hh < 0) hh -= 6;
                    ea = ((hh & 15) << 4) | (lo & 15);
                end
                ewr = 9; efwe = 15;
            end
        endcase
        efl = (((res >> 7) & 1) << 3) | ((res == 0 ? 1 : 0) << 2) | (cf << 1) | vf;
    endtask

    task automatic run_op(input int op, a, x, y, sp, m, hi, c, d);
        int ea, ex, esp, emem, ewr, efl, efwe;
        string rq;
        i_valid = 1'b1; i_op = op[3:0]; i_a = a[7:0]; i_x = x[7:0]; i_y = y[7:0];
        i_sp = sp[7:0]; i_m = m[7:0]; i_hi = hi[7:0]; i_c = c[0]; i_d = d[0];
        model(op, a, x, y, sp, m, hi, c, d, ea, ex, esp, emem, ewr, efl, efwe);
        rq = req_of(op, d[0]);
        @(negedge clk);
        check("R1", "valid", int'(o_valid), 1);
        check("R2", $sformatf("op%0d write enables", op),
              int'({o_wr_a, o_wr_x, o_wr_sp, o_wr_mem}), ewr);
        check("R2", $sformatf("op%0d flag enables", op), int'(o_flag_we), efwe);
        if (ewr[3]) check(rq, $sformatf("op%0d A", op), int'(o_a), ea);
        if (ewr[2]) check(rq, $sformatf("op%0d X", op), int'(o_x), ex);
        if (ewr[1]) check(rq, $sformatf("op%0d SP", op), int'(o_sp), esp);
        if (ewr[0]) check(rq, $sformatf("op%0d mem", op), int'(o_mem), emem);
        check(rq, $sformatf("op%0d flags", op), int'(o_flags & o_flag_we), efl & efwe);
    endtask

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; i_valid = 1'b0; i_op = '0; i_a = '0; i_x = '0; i_y = '0;
        i_sp = '0; i_m = '0; i_hi = '0; i_c = 1'b0; i_d = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset valid", int'(o_valid), 0);
        check("R1", "reset A", int'(o_a), 0);
        check("R1", "reset enables", int'({o_wr_a, o_wr_x, o_wr_sp, o_wr_mem, o_flag_we}), 0);
        rst = 1'b0;

        // directed corner cases
        run_op(0, 8'hF0, 0, 0, 0, 8'h8F, 0, 0, 0);   // R3 negative result, C follows N
        run_op(0, 8'h0F, 0, 0, 0, 8'hF0, 0, 1, 0);   // R3 zero result
        run_op(1, 8'hFF, 0, 0, 0, 8'h81, 0, 0, 0);   // R4 carry from bit 0
        run_op(2, 8'hFF, 0, 0, 0, 8'hC0, 0, 1, 0);   // R5 C and V rule
        run_op(2, 8'hFF, 0, 0, 0, 8'hA0, 0, 0, 1);   // R5 same rule in decimal mode
        run_op(4, 0, 0, 0, 8'h3C, 8'hF5, 0, 0, 0);   // R6 mask with SP
        run_op(6, 8'h01, 0, 0, 0, 8'hFF, 0, 0, 0);   // R7 magic constant
        run_op(7, 0, 0, 8'hFF, 0, 0, 8'hFF, 0, 0);   // R8 H+1 wraps to zero
        run_op(9, 8'hFF, 8'h7F, 0, 0, 0, 8'h3F, 0, 0); // R8 three-way mask
        run_op(13, 8'h45, 0, 0, 0, 8'h6A, 0, 1, 1);  // R13 decimal add with carry
        run_op(13, 8'h7F, 0, 0, 0, 8'h02, 0, 0, 0);  // R10 signed overflow
        run_op(14, 8'h41, 0, 0, 0, 8'h42, 0, 0, 0);  // R11 equal compare
        run_op(14, 8'h10, 0, 0, 0, 8'h00, 0, 0, 0);  // R11 M wraps to FF
        run_op(15, 8'h50, 0, 0, 0, 8'h18, 0, 0, 1);  // R13 decimal subtract with borrow
        run_op(15, 8'h80, 0, 0, 0, 8'h00, 0, 1, 0);  // R12 overflow on subtract

        // R1 idle cycle holds outputs
        held = o_a;
        i_valid = 1'b0; i_a = 8'h5A; i_op = 4'd3; i_m = 8'hA5;
        @(negedge clk);
        check("R1", "idle valid", int'(o_valid), 0);
        check("R1", "idle hold A", int'(o_a), int'(held));

        for (int k = 0; k < 600; k++) begin
            run_op($urandom_range(15), $urandom_range(255), $urandom_range(255),
                   $urandom_range(255), $urandom_range(255), $urandom_range(255),
                   $urandom_range(255), $urandom_range(1), $urandom_range(1));
        end
        i_valid = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule